// File: doc/BRIEF.md
# Channel Status Triple Buffer Controller

This block keeps three generations of channel-status and user data for a two-channel digital audio receiver. A capture stage writes the newest bytes into a staging buffer (D). On every audio block boundary the middle buffer (E) is handed on to the host-visible buffer (F), and the staging buffer is copied into E. Each of the two channel-status hand-offs can be held off on its own, so software can freeze what it reads or keep what it has loaded. User data always moves on a boundary.

The first few bytes of E can be write-protected against the D-to-E copy. The host can load those bytes directly, so a fixed status header survives every block. The host reads F through a byte-wide port. A configuration input chooses user or channel-status data. For channel-status reads there are two modes. In single-byte mode a channel-select input picks channel A or B. In paired mode successive reads alternate between A and B at the same byte index. The same channel select also drives an emphasis flag and a receiver status byte taken from byte 0 of F.

Top module: `csbuf_top`

## Requirements
- R1: After reset every byte of D, E and F is 0, `rd_data` is 0, `rd_valid` is 0, `rx_cs` is 0, `emph` is 0, and the paired-mode phase points at channel A.
- R2: On `blk_strobe`, E's user data takes D's user data. E's channel-status data takes D's channel-status data unless `cfg_inh_de` is 1, in which case it is left unchanged. Without a strobe or host write, E does not change.
- R3: On `blk_strobe`, F's user data takes the contents E held before the edge. F's channel-status data does the same unless `cfg_inh_ef` is 1, in which case F's channel-status data is left unchanged. F therefore always receives the previous E and never the same-cycle copy from D.
- R4: When `cfg_protect` is 1, a D-to-E channel-status copy leaves bytes 0 to 4 of E unchanged and updates bytes 5 to 23. When `cfg_protect` is 0, all 24 bytes are copied.
- R5: `hw_en` writes `hw_data` into E's channel-status byte `hw_idx` of channel `hw_chan` (0 = A, 1 = B) only when `hw_idx` is 0 to 4. Other indices are ignored. A host write takes precedence over a D-to-E copy of the same byte in the same cycle.
- R6: `cfg_user_sel` = 1 makes host reads return F's user data, and 0 makes them return F's channel-status data. User reads always use `cfg_chan_b` for the channel and do not advance the paired-mode phase.
- R7: In single-byte mode (`cfg_two_byte` = 0), a channel-status read returns channel A when `cfg_chan_b` = 0 and channel B when it is 1. The byte appears on `rd_data` with `rd_valid` = 1 one clock after `rd_en`. `rd_data` holds its value until the next read, and `rd_valid` is 0 when there was no read in the previous cycle.
- R8: In paired mode (`cfg_two_byte` = 1), successive channel-status reads alternate between channel A and channel B, starting with A. Any cycle with `cfg_two_byte` = 0 returns the phase to A.
- R9: `rx_cs` equals F's channel-status byte 0 of the channel chosen by `cfg_chan_b`. `emph` is 1 exactly when bits 5:3 of that byte equal 3'b001.
- R10: Read indices 24 and above return 0x00, and D writes with `dw_idx` of 24 or above change no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_strobe | input | 1 | Block boundary: shift E to F and D to E |
| dw_en | input | 1 | Write one byte into D |
| dw_user | input | 1 | D write target: 0 channel status, 1 user data |
| dw_chan | input | 1 | D write channel: 0 A, 1 B |
| dw_idx | input | 5 | D write byte index |
| dw_data | input | 8 | D write byte |
| hw_en | input | 1 | Host write into E channel-status bytes 0 to 4 |
| hw_chan | input | 1 | Host write channel: 0 A, 1 B |
| hw_idx | input | 5 | Host write byte index |
| hw_data | input | 8 | Host write byte |
| cfg_user_sel | input | 1 | Read space: 0 channel status, 1 user data |
| cfg_protect | input | 1 | Keep E bytes 0 to 4 on D-to-E copy |
| cfg_inh_de | input | 1 | Block channel-status D-to-E copy |
| cfg_inh_ef | input | 1 | Block channel-status E-to-F copy |
| cfg_two_byte | input | 1 | Paired A/B read mode for channel status |
| cfg_chan_b | input | 1 | Channel select: 0 A, 1 B |
| rd_en | input | 1 | Host read request |
| rd_idx | input | 5 | Host read byte index |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | Read byte valid, one clock after request |
| emph | output | 1 | Emphasis flag of the selected channel |
| rx_cs | output | 8 | Channel-status byte 0 of the selected channel |

## Verification
The chain is driven with all eight combinations of the two inhibits and the protect bit. D is refilled with a new arithmetic pattern before each pair of boundaries. Because each refill is distinct, a sweep of F can tell a copy that took E's old contents from one that took the fresh D. It also separates blocked stages from open ones and protected bytes from copied ones. Every byte of F is read for both data kinds and both channels. Paired-mode reads are interleaved with user reads and with mode exits, so that a phase that advances or resets at the wrong time shows up. Host writes are applied below, at, and above the protected range, and once in the same cycle as a boundary. Reads past the last index and the status outputs under both channel selects close the set.

// File: rtl/csbuf_pkg.sv
package csbuf_pkg;
    localparam int NUM_CH   = 2;
    localparam int NUM_KIND = 2;
    localparam int CS_SLOT  = 0;
    localparam int USR_SLOT = 1;
    localparam logic [2:0] EMPH_CODE = 3'b001;

    typedef struct packed {
        logic user_sel;
        logic protect;
        logic inh_de;
        logic inh_ef;
        logic two_byte;
        logic chan_b;
    } cfg_t;
endpackage

// File: rtl/csbuf_dbuf.sv
module csbuf_dbuf
    import csbuf_pkg::*;
#(
    parameter int NB = 24,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic                                      wr_kind,
    input  logic                                      wr_chan,
    input  logic [IDX_W-1:0]                          wr_idx,
    input  logic [7:0]                                wr_data,
    output logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] d_buf
);
    typedef struct packed {
        logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] mem;
    } dstate_t;

    dstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < NB)) begin
            st_d.mem[wr_kind][wr_chan][wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_buf = st_q.mem;
endmodule

// File: rtl/csbuf_chain.sv
module csbuf_chain
    import csbuf_pkg::*;
#(
    parameter int NB   = 24,
    parameter int PROT = 5,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      strobe,
    input  logic                                      inh_de,
    input  logic                                      inh_ef,
    input  logic                                      protect,
    input  logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] d_buf,
    input  logic                                      hw_en,
    input  logic                                      hw_chan,
    input  logic [IDX_W-1:0]                          hw_idx,
    input  logic [7:0]                                hw_data,
    output logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] e_buf,
    output logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] f_buf
);
    typedef struct packed {
        logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] e;
        logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] f;
    } cstate_t;

    cstate_t st_d, st_q;

    // Per-byte hold mask for the D-to-E copy; only the low PROT bytes can be held.
    logic [NB-1:0] keep_mask;
    for (genvar b = 0; b < NB; b++) begin : g_mask
        if (b < PROT) begin : g_lo
            assign keep_mask[b] = protect;
        end else begin : g_hi
            assign keep_mask[b] = 1'b0;
        end
    end

    logic host_hit;
    assign host_hit = hw_en && (int'(hw_idx) < PROT);

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            // Stage E to F first, from the registered E.
            st_d.f[USR_SLOT] = st_q.e[USR_SLOT];
            if (!inh_ef) begin
                st_d.f[CS_SLOT] = st_q.e[CS_SLOT];
            end
            // Then D to E.
            st_d.e[USR_SLOT] = d_buf[USR_SLOT];
            if (!inh_de) begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    for (int b = 0; b < NB; b++) begin
                        if (!keep_mask[b]) begin
                            st_d.e[CS_SLOT][ch][b] = d_buf[CS_SLOT][ch][b];
                        end
                    end
                end
            end
        end
        // Host write is applied last so it wins over a same-cycle copy.
        if (host_hit) begin
            st_d.e[CS_SLOT][hw_chan][hw_idx] = hw_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign e_buf = st_q.e;
    assign f_buf = st_q.f;
endmodule

// File: rtl/csbuf_rdport.sv
module csbuf_rdport
    import csbuf_pkg::*;
#(
    parameter int NB = 24,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  cfg_t                                      cfg,
    input  logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] f_buf,
    input  logic                                      rd_en,
    input  logic [IDX_W-1:0]                          rd_idx,
    output logic [7:0]                                rd_data,
    output logic                                      rd_valid,
    output logic                                      emph,
    output logic [7:0]                                rx_cs
);
    typedef struct packed {
        logic [7:0] data;
        logic       valid;
        logic       phase;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    slot;
    logic    chan;
    logic    paired;

    assign paired = cfg.two_byte && !cfg.user_sel;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en;
        slot       = cfg.user_sel;
        chan       = cfg.chan_b;
        if (!cfg.two_byte) begin
            st_d.phase = 1'b0;
        end
        if (rd_en) begin
            if (paired) begin
                chan       = st_q.phase;
                st_d.phase = ~st_q.phase;
            end
            if (int'(rd_idx) < NB) st_d.data = f_buf[slot][chan][rd_idx];
            else                   st_d.data = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;
    assign rx_cs    = f_buf[CS_SLOT][cfg.chan_b][0];
    assign emph     = (rx_cs[5:3] == EMPH_CODE);
endmodule

// File: rtl/csbuf_top.sv
module csbuf_top
    import csbuf_pkg::*;
#(
    parameter int NB   = 24,
    parameter int PROT = 5,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_strobe,
    input  logic             dw_en,
    input  logic             dw_user,
    input  logic             dw_chan,
    input  logic [IDX_W-1:0] dw_idx,
    input  logic [7:0]       dw_data,
    input  logic             hw_en,
    input  logic             hw_chan,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic [7:0]       hw_data,
    input  logic             cfg_user_sel,
    input  logic             cfg_protect,
    input  logic             cfg_inh_de,
    input  logic             cfg_inh_ef,
    input  logic             cfg_two_byte,
    input  logic             cfg_chan_b,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             emph,
    output logic [7:0]       rx_cs
);
    cfg_t cfg;
    assign cfg = '{user_sel: cfg_user_sel, protect: cfg_protect, inh_de: cfg_inh_de,
                   inh_ef: cfg_inh_ef, two_byte: cfg_two_byte, chan_b: cfg_chan_b};

    logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] d_buf;
    logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] e_buf;
    logic [NUM_KIND-1:0][NUM_CH-1:0][NB-1:0][7:0] f_buf;

    csbuf_dbuf #(.NB(NB)) u_dbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dw_en), .wr_kind(dw_user), .wr_chan(dw_chan),
        .wr_idx(dw_idx), .wr_data(dw_data),
        .d_buf(d_buf)
    );

    csbuf_chain #(.NB(NB), .PROT(PROT)) u_chain (
        .clk(clk), .rst_n(rst_n), .strobe(blk_strobe),
        .inh_de(cfg.inh_de), .inh_ef(cfg.inh_ef), .protect(cfg.protect),
        .d_buf(d_buf),
        .hw_en(hw_en), .hw_chan(hw_chan), .hw_idx(hw_idx), .hw_data(hw_data),
        .e_buf(e_buf), .f_buf(f_buf)
    );

    csbuf_rdport #(.NB(NB)) u_rd (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .f_buf(f_buf),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .emph(emph), .rx_cs(rx_cs)
    );
endmodule

// File: rtl/csbuf_chk.sv
module csbuf_chk
    import csbuf_pkg::*;
#(
    parameter int NB   = 24,
    parameter int PROT = 5,
    localparam int IDX_W = $clog2(NB)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          strobe,
    input logic                          inh_de,
    input logic                          inh_ef,
    input logic                          protect,
    input logic                          hw_en,
    input logic [IDX_W-1:0]              hw_idx,
    input logic                          rd_en,
    input logic                          rd_valid,
    input logic [NUM_CH-1:0][NB-1:0][7:0] e_cs,
    input logic [NUM_CH-1:0][NB-1:0][7:0] f_cs
);
    logic [NUM_CH-1:0][PROT-1:0][7:0] e_low;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_low
        assign e_low[c] = e_cs[c][PROT-1:0];
    end

    AST_DE_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && inh_de && !hw_en |=> $stable(e_cs)); // R2

    AST_E_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe && !hw_en |=> $stable(e_cs)); // R2

    AST_EF_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && inh_ef |=> $stable(f_cs)); // R3

    AST_EF_TAKES_OLD_E: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !inh_ef |=> f_cs == $past(e_cs)); // R3

    AST_PROTECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && protect && !hw_en |=> e_low == $past(e_low)); // R4

    AST_HOST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe && hw_en && (int'(hw_idx) >= PROT) |=> $stable(e_cs)); // R5

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R7

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R7
endmodule

bind csbuf_top csbuf_chk #(.NB(NB), .PROT(PROT)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(blk_strobe),
    .inh_de(cfg_inh_de), .inh_ef(cfg_inh_ef), .protect(cfg_protect),
    .hw_en(hw_en), .hw_idx(hw_idx),
    .rd_en(rd_en), .rd_valid(rd_valid),
    .e_cs(e_buf[0]), .f_cs(f_buf[0])
);

// File: tb/csbuf_top_test.sv
`timescale 1ns/1ps
module csbuf_top_test;
    localparam int NB = 24;
    localparam int PR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_strobe = 0, dw_en = 0, dw_user = 0, dw_chan = 0;
    logic [4:0] dw_idx = '0, hw_idx = '0, rd_idx = '0;
    logic [7:0] dw_data = '0, hw_data = '0;
    logic hw_en = 0, hw_chan = 0, rd_en = 0;
    logic cfg_user_sel = 0, cfg_protect = 0, cfg_inh_de = 0, cfg_inh_ef = 0;
    logic cfg_two_byte = 0, cfg_chan_b = 0;
    logic [7:0] rd_data, rx_cs;
    logic rd_valid, emph;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] md [2][2][NB];
    logic [7:0] me [2][2][NB];
    logic [7:0] mf [2][2][NB];

    always #2 clk = ~clk;

    csbuf_top uut (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(int seed, int k, int ch, int b);
        return 8'((seed * 29 + k * 97 + ch * 61 + b * 13 + 5) & 255);
    endfunction

    // One cycle of boundary and/or host write; model follows the requirements.
    task automatic act(input bit stb, input bit hw, input int hch, input int hidx, input logic [7:0] hd);
        @(negedge clk);
        blk_strobe = stb; hw_en = hw; hw_chan = hch[0]; hw_idx = 5'(hidx); hw_data = hd;
        if (stb) begin
            for (int k = 0; k < 2; k++) for (int c = 0; c < 2; c++) for (int b = 0; b < NB; b++)
                if (k == 1 || !cfg_inh_ef) mf[k][c][b] = me[k][c][b];
            for (int k = 0; k < 2; k++) for (int c = 0; c < 2; c++) for (int b = 0; b < NB; b++)
                if (k == 1 || (!cfg_inh_de && !(cfg_protect && b < PR))) me[k][c][b] = md[k][c][b];
        end
        if (hw && hidx < PR) me[0][hch][hidx] = hd;
        @(negedge clk);
        blk_strobe = 0; hw_en = 0;
    endtask

    task automatic dwrite(input int k, input int ch, input int idx, input logic [7:0] v);
        @(negedge clk);
        dw_en = 1; dw_user = k[0]; dw_chan = ch[0]; dw_idx = 5'(idx); dw_data = v;
        if (idx < NB) md[k][ch][idx] = v;
        @(negedge clk);
        dw_en = 0;
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < 2; k++) for (int c = 0; c < 2; c++) for (int b = 0; b < NB; b++)
            dwrite(k, c, b, pat(seed, k, c, b));
    endtask

    task automatic rd_check(input string tag, input int idx, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1; rd_idx = 5'(idx);
        @(negedge clk);
        rd_en = 0;
        check(tag, rd_data, exp);
    endtask

    task automatic sweep(input string tag);
        cfg_two_byte = 0;
        for (int k = 0; k < 2; k++) for (int c = 0; c < 2; c++) begin
            cfg_user_sel = k[0]; cfg_chan_b = c[0];
            for (int b = 0; b < NB; b++) rd_check(tag, b, mf[k][c][b]);
        end
        cfg_user_sel = 0; cfg_chan_b = 0;
    endtask

    initial begin
        for (int k = 0; k < 2; k++) for (int c = 0; c < 2; c++) for (int b = 0; b < NB; b++) begin
            md[k][c][b] = 0; me[k][c][b] = 0; mf[k][c][b] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_valid", rd_valid, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 rx_cs", rx_cs, 0);
        check("R1 emph", emph, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 rd_valid after release", rd_valid, 0);
        rd_check("R1 empty F", 7, 8'h00);

        // R2 R3 R4: all inhibit/protect combinations, two boundaries per fill
        for (int c = 0; c < 8; c++) begin
            cfg_inh_de = c[0]; cfg_inh_ef = c[1]; cfg_protect = c[2];
            fill(c + 1);
            act(1, 0, 0, 0, 0);
            sweep("R2/R3/R4 first boundary");
            act(1, 0, 0, 0, 0);
            sweep("R2/R3/R4 second boundary");
        end
        cfg_inh_de = 0; cfg_inh_ef = 0; cfg_protect = 0;
        fill(40); act(1, 0, 0, 0, 0); fill(41); act(1, 0, 0, 0, 0);
        sweep("R3 ordering");

        // R7 valid timing and hold
        @(negedge clk); rd_en = 1; rd_idx = 5'd3;
        @(negedge clk); rd_en = 0;
        check("R7 valid", rd_valid, 1);
        check("R7 data", rd_data, mf[0][0][3]);
        @(negedge clk);
        check("R7 valid drops", rd_valid, 0);
        check("R7 data holds", rd_data, mf[0][0][3]);

        // R8 paired mode
        cfg_two_byte = 1; cfg_user_sel = 0; cfg_chan_b = 1;
        for (int b = 0; b < NB; b++) begin
            rd_check("R8 pair A", b, mf[0][0][b]);
            rd_check("R8 pair B", b, mf[0][1][b]);
        end
        rd_check("R8 A", 3, mf[0][0][3]);
        cfg_user_sel = 1;
        rd_check("R6 user B in paired mode", 3, mf[1][1][3]);
        cfg_user_sel = 0;
        rd_check("R8 phase kept across user read", 3, mf[0][1][3]);
        rd_check("R8 wraps to A", 4, mf[0][0][4]);
        cfg_two_byte = 0;
        rd_check("R7 single-byte chan B", 4, mf[0][1][4]);
        cfg_two_byte = 1;
        rd_check("R8 restart at A", 5, mf[0][0][5]);
        cfg_two_byte = 0; cfg_chan_b = 0;

        // R5 host writes
        cfg_inh_de = 1;
        for (int i = 0; i < PR; i++) act(0, 1, 1, i, 8'hA0 + 8'(i));
        act(0, 1, 1, 9, 8'h55);
        act(0, 1, 0, 23, 8'h66);
        act(1, 0, 0, 0, 0);
        sweep("R5 host write");
        cfg_inh_de = 0;
        fill(50);
        act(1, 1, 0, 2, 8'h3C);
        act(1, 0, 0, 0, 0);
        sweep("R5 host wins");
        rd_check("R5 host byte", 2, 8'h3C);

        // R4 with host-loaded header
        cfg_protect = 1;
        for (int i = 0; i < PR; i++) act(0, 1, 0, i, 8'hC0 + 8'(i));
        fill(60);
        act(1, 0, 0, 0, 0); act(1, 0, 0, 0, 0);
        for (int i = 0; i < PR; i++) rd_check("R4 header kept", i, 8'hC0 + 8'(i));
        rd_check("R4 body copied", 5, pat(60, 0, 0, 5));
        cfg_protect = 0;

        // R9 status outputs
        dwrite(0, 0, 0, 8'h08);
        dwrite(0, 1, 0, 8'h10);
        act(1, 0, 0, 0, 0); act(1, 0, 0, 0, 0);
        cfg_chan_b = 0; #1;
        check("R9 rx_cs A", rx_cs, 8'h08);
        check("R9 emph A", emph, 1);
        cfg_chan_b = 1; #1;
        check("R9 rx_cs B", rx_cs, 8'h10);
        check("R9 emph B", emph, 0);
        cfg_chan_b = 0;

        // R10 out-of-range
        for (int b = NB; b < 32; b++) rd_check("R10 high read", b, 8'h00);
        dwrite(0, 0, 28, 8'hEE);
        dwrite(1, 1, 31, 8'hEE);
        act(1, 0, 0, 0, 0); act(1, 0, 0, 0, 0);
        sweep("R10 high D write");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule